// File: doc/BRIEF.md
# Watchdog Control Register with Reset-Source Rules

This block is the watchdog control register of an 8-bit microcontroller, reached over the special-function register bus. It holds five working bits: a power-up flag, a watchdog interrupt flag, a flag recording that the last reset came from a watchdog timeout, the watchdog enable and the watchdog restart request. The enable and restart bits drive the watchdog counter, which sits outside this block.

Each bit follows its own rule on reset, and the rule depends on which source caused the reset. Three synchronous, active-high reset inputs (power-up, watchdog timeout and external pin) pass through a priority arbiter. While any of them is high, the register loads the values that belong to the winning source. Four of the bits are guarded. A write changes them only inside a short window, and the window opens when two key bytes are written to a separate unlock address on back-to-back clock cycles. The timeout flag has no guard. Reads are never restricted.

Top module: `wdt_ctl_reg`

## Requirements
- R1: While the power-up reset input is high, the register holds 0x40. This value sets bit 6 (power-up flag) and clears bits 3 (interrupt flag), 2 (timeout flag), 1 (enable) and 0 (restart).
- R2: While the watchdog reset input is the winning source, bit 2 is 1, bits 6, 3 and 0 are 0, and bit 1 keeps its previous value.
- R3: While the external reset input is the only source, bits 2 and 1 keep their previous values and bits 6, 3 and 0 are 0.
- R4: If several reset inputs are high in the same cycle, power-up wins over watchdog, and watchdog wins over external.
- R5: While any reset input is high, the reset values are held and bus writes to the register have no effect. Reads still return the held value.
- R6: Bit 2 takes the written value on any write to the control address (default 0xD8).
- R7: Bits 6, 3, 1 and 0 ignore a write made while the unlock window is closed. Bit 2 in the same write still updates.
- R8: Writing 0xAA and then 0x55 to the unlock address (default 0xC7) on consecutive cycles opens the window for the next 3 cycles. Guarded writes made in those cycles take effect, and a write in the fourth cycle is ignored.
- R9: A key pair with an idle cycle between its two writes does not open the window. Neither does a key pair written in the wrong order.
- R10: A high level on the interrupt-set input sets bit 3 at the next clock edge. This set wins over a guarded write that would clear bit 3 in the same cycle.
- R11: Read data appears one cycle after a read strobe to the control address, with bits 7, 5 and 4 reading 0. In any other cycle the read data is 0.
- R12: The enable output follows bit 1 and the restart output follows bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_i | input | 1 | Power-up reset, synchronous, active high |
| wdt_rst_i | input | 1 | Watchdog timeout reset, synchronous, active high |
| ext_rst_i | input | 1 | External pin reset, synchronous, active high |
| sfr_addr_i | input | ADDR_W | Register bus address |
| sfr_rd_i | input | 1 | Read strobe |
| sfr_wr_i | input | 1 | Write strobe |
| sfr_wdata_i | input | 8 | Write data |
| sfr_rdata_o | output | 8 | Registered read data |
| wdi_set_i | input | 1 | Sets the watchdog interrupt flag |
| wd_en_o | output | 1 | Watchdog enable (bit 1) |
| wd_restart_o | output | 1 | Watchdog restart request (bit 0) |

## Verification
The checks assume that the bus raises at most one strobe per cycle, and that every reset input is synchronous to the clock and lasts at least one full cycle. The assertions compare the enable output with its value one cycle earlier. For that reason they stay disabled until two edges have passed after time zero, and the stimulus always begins with a power-up reset so that the kept bits never start unknown. The bench changes every input just after a rising edge and drives only one bus operation per cycle. As a result, the unlock sequences, the gaps inside them and the clashes between the interrupt-set input and a clearing write each fall on a known edge.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int DATA_W   = 8;
  localparam int BIT_PWR  = 6;
  localparam int BIT_IRQ  = 3;
  localparam int BIT_TMO  = 2;
  localparam int BIT_EN   = 1;
  localparam int BIT_RST  = 0;

  localparam logic [DATA_W-1:0] IMPL_MASK = 8'b0100_1111;
  localparam logic [DATA_W-1:0] GUARD_MASK = 8'b0100_1011;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PWR  = 2'd1,
    SRC_WDT  = 2'd2,
    SRC_PIN  = 2'd3
  } rst_src_e;

  // Bits forced to 1 by a reset source.
  function automatic logic [DATA_W-1:0] set_mask(rst_src_e src);
    case (src)
      SRC_PWR: set_mask = 8'b0100_0000;
      SRC_WDT: set_mask = 8'b0000_0100;
      default: set_mask = 8'b0000_0000;
    endcase
  endfunction

  // Bits that keep their value across a reset source.
  function automatic logic [DATA_W-1:0] keep_mask(rst_src_e src);
    case (src)
      SRC_WDT: keep_mask = 8'b0000_0010;
      SRC_PIN: keep_mask = 8'b0000_0110;
      default: keep_mask = 8'b0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/wdc_rst_arb.sv
module wdc_rst_arb
  import wdc_pkg::*;
(
  input  logic     pwr_i,
  input  logic     wdt_i,
  input  logic     pin_i,
  output rst_src_e src_o,
  output logic     act_o
);
  always_comb begin
    if (pwr_i)      src_o = SRC_PWR;
    else if (wdt_i) src_o = SRC_WDT;
    else if (pin_i) src_o = SRC_PIN;
    else            src_o = SRC_NONE;
  end

  assign act_o = pwr_i | wdt_i | pin_i;
endmodule

// File: rtl/wdc_unlock.sv
module wdc_unlock #(
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hC7,
  parameter logic [7:0]      KEY_FIRST  = 8'hAA,
  parameter logic [7:0]      KEY_SECOND = 8'h55,
  parameter int              WIN_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              open_o
);
  localparam int CW = $clog2(WIN_CYCLES + 1);

  logic          key_wr;
  logic          armed_q;
  logic [CW-1:0] left_q;

  assign key_wr = wr_i && (addr_i == KEY_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      left_q  <= '0;
    end else begin
      armed_q <= key_wr && (wdata_i == KEY_FIRST);
      if (armed_q && key_wr && (wdata_i == KEY_SECOND))
        left_q <= CW'(WIN_CYCLES);
      else if (left_q != '0)
        left_q <= left_q - 1'b1;
    end
  end

  assign open_o = (left_q != '0);
endmodule

// File: rtl/wdc_bits.sv
module wdc_bits
  import wdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_act_i,
  input  rst_src_e          src_i,
  input  logic              wr_ctl_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              open_i,
  input  logic              irq_set_i,
  output logic [DATA_W-1:0] ctl_o
);
  logic [DATA_W-1:0] set_m;
  logic [DATA_W-1:0] keep_m;

  assign set_m  = set_mask(src_i);
  assign keep_m = keep_mask(src_i);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      logic q;
      logic hw_set;
      logic wr_ok;
      assign hw_set = (i == BIT_IRQ) ? irq_set_i : 1'b0;
      assign wr_ok  = wr_ctl_i && (!GUARD_MASK[i] || open_i);
      always_ff @(posedge clk) begin
        if (rst_act_i)   q <= set_m[i] | (keep_m[i] & q);
        else if (hw_set) q <= 1'b1;
        else if (wr_ok)  q <= wdata_i[i];
      end
      assign ctl_o[i] = q;
    end else begin : g_void
      assign ctl_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
  import wdc_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR   = 8'hD8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hC7,
  parameter int                WIN_CYCLES = 3
) (
  input  logic              clk,
  input  logic              por_rst_i,
  input  logic              wdt_rst_i,
  input  logic              ext_rst_i,
  input  logic [ADDR_W-1:0] sfr_addr_i,
  input  logic              sfr_rd_i,
  input  logic              sfr_wr_i,
  input  logic [7:0]        sfr_wdata_i,
  output logic [7:0]        sfr_rdata_o,
  input  logic              wdi_set_i,
  output logic              wd_en_o,
  output logic              wd_restart_o
);
  rst_src_e          src;
  logic              rst_act;
  logic              win_open;
  logic [DATA_W-1:0] ctl;
  logic              wr_ctl;

  wdc_rst_arb u_arb (
    .pwr_i (por_rst_i),
    .wdt_i (wdt_rst_i),
    .pin_i (ext_rst_i),
    .src_o (src),
    .act_o (rst_act)
  );

  wdc_unlock #(
    .ADDR_W     (ADDR_W),
    .KEY_ADDR   (KEY_ADDR),
    .WIN_CYCLES (WIN_CYCLES)
  ) u_unlock (
    .clk     (clk),
    .rst     (rst_act),
    .wr_i    (sfr_wr_i),
    .addr_i  (sfr_addr_i),
    .wdata_i (sfr_wdata_i),
    .open_o  (win_open)
  );

  assign wr_ctl = sfr_wr_i && (sfr_addr_i == CTL_ADDR);

  wdc_bits u_bits (
    .clk       (clk),
    .rst_act_i (rst_act),
    .src_i     (src),
    .wr_ctl_i  (wr_ctl),
    .wdata_i   (sfr_wdata_i),
    .open_i    (win_open),
    .irq_set_i (wdi_set_i),
    .ctl_o     (ctl)
  );

  always_ff @(posedge clk) begin
    if (sfr_rd_i && (sfr_addr_i == CTL_ADDR)) sfr_rdata_o <= ctl;
    else                                      sfr_rdata_o <= '0;
  end

  assign wd_en_o      = ctl[BIT_EN];
  assign wd_restart_o = ctl[BIT_RST];
endmodule

// File: rtl/wdc_ctl_chk.sv
module wdc_ctl_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'hD8
) (
  input logic              clk,
  input logic              por_rst_i,
  input logic              wdt_rst_i,
  input logic              ext_rst_i,
  input logic [ADDR_W-1:0] sfr_addr_i,
  input logic              sfr_rd_i,
  input logic              sfr_wr_i,
  input logic [7:0]        sfr_rdata_o,
  input logic              wd_en_o,
  input logic              wd_restart_o
);
  logic [1:0] live_q = 2'd0;
  always_ff @(posedge clk) if (live_q != 2'd2) live_q <= live_q + 2'd1;

  logic live;
  assign live = (live_q == 2'd2);

  // R1
  pwr_clears_chk: assert property (@(posedge clk) disable iff (!live)
    por_rst_i |=> (!wd_en_o && !wd_restart_o));

  // R2
  wdt_keeps_en_chk: assert property (@(posedge clk) disable iff (!live)
    (wdt_rst_i && !por_rst_i) |=> (wd_en_o == $past(wd_en_o)));

  // R3
  pin_keeps_en_chk: assert property (@(posedge clk) disable iff (!live)
    (ext_rst_i && !wdt_rst_i && !por_rst_i) |=> (wd_en_o == $past(wd_en_o) && !wd_restart_o));

  // R5
  rst_blocks_wr_chk: assert property (@(posedge clk) disable iff (!live)
    ((por_rst_i || wdt_rst_i || ext_rst_i) && sfr_wr_i) |=> !wd_restart_o);

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!live)
    !(sfr_rd_i && sfr_addr_i == CTL_ADDR) |=> (sfr_rdata_o == 8'h00));

  // R11
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!live)
    sfr_rd_i |=> (sfr_rdata_o[7] == 1'b0 && sfr_rdata_o[5:4] == 2'b00));
endmodule

bind wdt_ctl_reg wdc_ctl_chk #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_chk (
  .clk          (clk),
  .por_rst_i    (por_rst_i),
  .wdt_rst_i    (wdt_rst_i),
  .ext_rst_i    (ext_rst_i),
  .sfr_addr_i   (sfr_addr_i),
  .sfr_rd_i     (sfr_rd_i),
  .sfr_wr_i     (sfr_wr_i),
  .sfr_rdata_o  (sfr_rdata_o),
  .wd_en_o      (wd_en_o),
  .wd_restart_o (wd_restart_o)
);

// File: tb/wdt_ctl_reg_tb.sv
module wdt_ctl_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CTL = 8'hD8;
  localparam logic [7:0] KEY = 8'hC7;

  logic       clk = 1'b0;
  logic       por_rst = 1'b0, wdt_rst = 1'b0, ext_rst = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       wdi = 1'b0;
  logic       en, rstr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_ctl_reg u_dut (
    .clk(clk), .por_rst_i(por_rst), .wdt_rst_i(wdt_rst), .ext_rst_i(ext_rst),
    .sfr_addr_i(addr), .sfr_rd_i(rd), .sfr_wr_i(wr), .sfr_wdata_i(wdata),
    .sfr_rdata_o(rdata), .wdi_set_i(wdi), .wd_en_o(en), .wd_restart_o(rstr)
  );

  // Monitor: a read seen in one half-period is compared one cycle later.
  bit pend = 0;
  always @(negedge clk) begin
    if (pend) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: got %02h expected none", rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rdata !== e.val) begin
          n_bad++;
          $display("FAIL %s: got %02h expected %02h", e.tag, rdata, e.val);
        end
      end
    end
    pend = rd && (addr == CTL);
  end

  task automatic idle();
    @(posedge clk); #1;
    rd = 0; wr = 0; wdi = 0; addr = 8'h00; wdata = 8'h00;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    rd = 0; wr = 1; addr = a; wdata = d;
  endtask

  task automatic unlock();
    wr_reg(KEY, 8'hAA);
    wr_reg(KEY, 8'h55);
  endtask

  task automatic rd_exp(input logic [7:0] v, input string tag);
    exp_t e;
    @(posedge clk); #1;
    wr = 0; wdi = 0; rd = 1; addr = CTL;
    e.val = v; e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #1;
    rd = 0; addr = 8'h00;
  endtask

  task automatic pulse_rst(input bit p, input bit w, input bit x);
    @(posedge clk); #1;
    por_rst = p; wdt_rst = w; ext_rst = x;
    rd = 0; wr = 0;
    repeat (2) @(posedge clk);
    #1; por_rst = 0; wdt_rst = 0; ext_rst = 0;
  endtask

  task automatic port_chk(input logic got, input logic exp, input string tag);
    @(negedge clk);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 power-up values, read during and after reset (R5 read allowed)
    @(posedge clk); #1; por_rst = 1;
    repeat (2) @(posedge clk);
    rd_exp(8'h40, "R5 read during power-up reset");
    #0 por_rst = 0;
    rd_exp(8'h40, "R1 power-up value");
    port_chk(en, 1'b0, "R1 enable low");
    port_chk(rdata, 1'b0, "R11 idle read data");

    // R7 / R6 unguarded write
    wr_reg(CTL, 8'hFF); idle();
    rd_exp(8'h44, "R7 guarded bits ignore, R6 bit2 set");
    wr_reg(CTL, 8'h00); idle();
    rd_exp(8'h40, "R6 bit2 cleared");

    // R8 write in first window cycle
    unlock(); wr_reg(CTL, 8'h0B); idle();
    rd_exp(8'h0B, "R8 first window cycle");
    port_chk(en, 1'b1, "R12 enable output");
    port_chk(rstr, 1'b1, "R12 restart output");

    // R8 third window cycle accepted
    unlock(); idle(); idle(); wr_reg(CTL, 8'h02); idle();
    rd_exp(8'h02, "R8 third window cycle");
    // R8 fourth cycle refused
    unlock(); idle(); idle(); idle(); wr_reg(CTL, 8'h00); idle();
    rd_exp(8'h02, "R8 fourth cycle closed");

    // R9 broken sequences
    wr_reg(KEY, 8'hAA); idle(); wr_reg(KEY, 8'h55); wr_reg(CTL, 8'h00); idle();
    rd_exp(8'h02, "R9 gap between keys");
    wr_reg(KEY, 8'h55); wr_reg(KEY, 8'hAA); wr_reg(CTL, 8'h00); idle();
    rd_exp(8'h02, "R9 keys reversed");

    // R10 interrupt set and its priority over a clearing write
    @(posedge clk); #1; wdi = 1; idle();
    rd_exp(8'h0A, "R10 set input");
    unlock(); wr_reg(CTL, 8'h02); wdi = 1; idle();
    rd_exp(8'h0A, "R10 set beats clearing write");
    unlock(); wr_reg(CTL, 8'h02); idle();
    rd_exp(8'h02, "R10 clear without set");

    // R2 watchdog reset
    pulse_rst(0, 1, 0);
    rd_exp(8'h06, "R2 watchdog reset value");
    port_chk(en, 1'b1, "R2 enable kept");

    // R3 external reset keeps bits 2 and 1
    pulse_rst(0, 0, 1);
    rd_exp(8'h06, "R3 external keeps bit2");
    unlock(); wr_reg(CTL, 8'h0B); idle();
    pulse_rst(0, 0, 1);
    rd_exp(8'h02, "R3 external clears 3 and 0");

    // R4 priority
    pulse_rst(0, 1, 1);
    rd_exp(8'h06, "R4 watchdog over external");
    pulse_rst(1, 1, 1);
    rd_exp(8'h40, "R4 power-up wins");

    // R5 writes ignored during reset
    unlock(); wr_reg(CTL, 8'h02); idle();
    @(posedge clk); #1; ext_rst = 1; wr = 1; addr = CTL; wdata = 8'h04;
    repeat (2) @(posedge clk);
    #1; wr = 0; ext_rst = 0;
    rd_exp(8'h02, "R5 write during reset ignored");

    repeat (4) @(negedge clk);
    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard drain: got %0d expected 0", sb.size());
    end
    finish_run();
  end
endmodule